// File: doc/BRIEF.md
# Supply Trip-Threshold Programming Sequencer

This block sits behind a two-wire serial bus receiver and watches for the one command frame that retunes a supply-voltage trip threshold. The receiver hands it START and STOP pulses and complete received bytes. A frame is a device byte, an address high byte, an address low byte and a data byte. The address low byte picks one of two operations: raise the threshold to a new value, or return it to its low native level. The frame is only considered when the write-enable latch was set when the frame opened and the programming voltage was present on the protect pin during the whole frame.

The operation is launched by the STOP that closes a well-formed frame, not by its last byte. From then on the block drives exactly one request line, along with busy. It holds both steady until the programming voltage is removed from the protect pin, which ends the operation. While an operation runs, the bus is ignored. Afterwards a fresh START is needed before another frame can be recognised.

Top module: `vtrip_prog_seq`

## Requirements
- R1: After reset, busy, set_req and clr_req are all low.
- R2: The frame START, A0h, 00h, 01h, 00h, STOP raises busy and set_req in the cycle after the STOP is sampled. This needs wel high at the START and hv_on_wp high at every byte and at the STOP.
- R3: The same frame with the third byte 03h raises busy and clr_req instead.
- R4: wel is sampled only on the START cycle. A frame opened with wel low produces no request, even if wel rises later in the frame.
- R5: If hv_on_wp is low on any byte of the frame, or on the STOP cycle, no request is produced.
- R6: Any byte that differs from the pattern in R2 or R3 abandons the frame, and no request is produced.
- R7: A STOP after fewer than four bytes, or after a fifth byte, produces no request.
- R8: A START in the middle of a frame drops the partial frame and restarts matching at the device byte. A complete frame that follows is acted on.
- R9: set_req and clr_req are never high together. Whichever one is high equals busy and stays constant while hv_on_wp stays high.
- R10: When hv_on_wp is sampled low while busy, busy and the request are low from the next cycle.
- R11: While busy, bus events are ignored. After busy clears, bytes and a STOP without a new START produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_start | input | 1 | One-cycle pulse: START condition seen on the bus |
| bus_stop | input | 1 | One-cycle pulse: STOP condition seen on the bus |
| byte_vld | input | 1 | One-cycle pulse: byte_data holds a newly received byte |
| byte_data | input | 8 | Received byte |
| wel | input | 1 | Write-enable latch bit |
| hv_on_wp | input | 1 | High while the programming voltage is present on the protect pin |
| set_req | output | 1 | Request to program a new threshold |
| clr_req | output | 1 | Request to return the threshold to its native level |
| busy | output | 1 | A programming operation is in progress |

## Verification
The bench targets the disqualifiers. In one case wel rises only after the START; a design that samples wel at the STOP would wrongly launch. In another hv_on_wp drops on a single byte and then returns; a design that checks it only at the STOP would wrongly launch. A fifth byte before the STOP must fail the frame; a position counter that saturates would accept it. A repeated START after a valid prefix must restart matching, or the following good frame is lost. While busy, a second frame of the other kind is sent: a design that keeps listening would flip the request. After release, bytes without a START are sent: a design that does not return to idle would launch from them.

// File: rtl/vtrip_prog_pkg.sv
package vtrip_prog_pkg;
  localparam int unsigned FRAME_BYTES = 4;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_OPEN = 2'd1,
    TRK_DEAD = 2'd2
  } trk_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } trim_op_e;
endpackage

// File: rtl/vtrip_rst_sync.sv
module vtrip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/vtrip_frame_track.sv
module vtrip_frame_track
  import vtrip_prog_pkg::*;
#(
  parameter int unsigned BW        = 8,
  parameter logic [BW-1:0] DEV_CODE  = 8'hA0,
  parameter logic [BW-1:0] ADDR_HI   = 8'h00,
  parameter logic [BW-1:0] SET_LO    = 8'h01,
  parameter logic [BW-1:0] CLR_LO    = 8'h03,
  parameter logic [BW-1:0] DATA_CODE = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [BW-1:0] byte_i,
  input  logic          wel_i,
  input  logic          hv_i,
  output logic          frame_ok_o,
  output trim_op_e      op_o
);
  localparam int unsigned IW = $clog2(FRAME_BYTES + 1);
  localparam logic [IW-1:0] LAST_POS = IW'(FRAME_BYTES);

  trk_state_e st_q, st_d;
  logic [IW-1:0] pos_q, pos_d;
  trim_op_e op_q, op_d;
  logic wel_q, wel_d;
  logic byte_ok;
  trim_op_e lo_op;
  logic adv;

  // byte expected at the current frame position
  always_comb begin
    byte_ok = 1'b0;
    lo_op   = OP_NONE;
    case (pos_q)
      IW'(0): byte_ok = (byte_i == DEV_CODE);
      IW'(1): byte_ok = (byte_i == ADDR_HI);
      IW'(2): begin
        if (byte_i == SET_LO) begin
          byte_ok = 1'b1;
          lo_op   = OP_SET;
        end else if (byte_i == CLR_LO) begin
          byte_ok = 1'b1;
          lo_op   = OP_CLR;
        end
      end
      IW'(3): byte_ok = (byte_i == DATA_CODE);
      default: byte_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    op_d  = op_q;
    wel_d = wel_q;
    if (hold_i) begin
      st_d = TRK_IDLE;
    end else if (start_i) begin
      st_d  = TRK_OPEN;
      pos_d = '0;
      op_d  = OP_NONE;
      wel_d = wel_i;
    end else if (stop_i) begin
      st_d = TRK_IDLE;
    end else if (byte_vld_i && st_q == TRK_OPEN) begin
      if (!hv_i || !byte_ok) begin
        st_d = TRK_DEAD;
      end else begin
        pos_d = pos_q + IW'(1);
        if (pos_q == IW'(2)) op_d = lo_op;
      end
    end
  end

  assign adv = hold_i | start_i | stop_i | byte_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRK_IDLE;
      pos_q <= '0;
      op_q  <= OP_NONE;
      wel_q <= 1'b0;
    end else if (adv) begin
      st_q  <= st_d;
      pos_q <= pos_d;
      op_q  <= op_d;
      wel_q <= wel_d;
    end
  end

  assign frame_ok_o = stop_i && !start_i && !hold_i && (st_q == TRK_OPEN) &&
                      (pos_q == LAST_POS) && wel_q && hv_i;
  assign op_o = op_q;
endmodule

// File: rtl/vtrip_launch_ctrl.sv
module vtrip_launch_ctrl
  import vtrip_prog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_ok_i,
  input  trim_op_e op_i,
  input  logic     hv_i,
  output logic     busy_o,
  output logic     set_o,
  output logic     clr_o
);
  logic     busy_q, busy_d;
  trim_op_e op_q, op_d;
  logic     upd;

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    if (busy_q) begin
      if (!hv_i) begin
        busy_d = 1'b0;
        op_d   = OP_NONE;
      end
    end else if (frame_ok_i) begin
      busy_d = 1'b1;
      op_d   = op_i;
    end
  end

  assign upd = busy_q ? !hv_i : frame_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end else if (upd) begin
      busy_q <= busy_d;
      op_q   <= op_d;
    end
  end

  assign busy_o = busy_q;
  assign set_o  = (op_q == OP_SET);
  assign clr_o  = (op_q == OP_CLR);
endmodule

// File: rtl/vtrip_prog_seq.sv
module vtrip_prog_seq
  import vtrip_prog_pkg::*;
#(
  parameter int unsigned BW        = 8,
  parameter logic [BW-1:0] DEV_CODE  = 8'hA0,
  parameter logic [BW-1:0] ADDR_HI   = 8'h00,
  parameter logic [BW-1:0] SET_LO    = 8'h01,
  parameter logic [BW-1:0] CLR_LO    = 8'h03,
  parameter logic [BW-1:0] DATA_CODE = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_data,
  input  logic          wel,
  input  logic          hv_on_wp,
  output logic          set_req,
  output logic          clr_req,
  output logic          busy
);
  logic     rst_n_i;
  logic     frame_ok;
  trim_op_e frame_op;

  vtrip_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  vtrip_frame_track #(
    .BW(BW), .DEV_CODE(DEV_CODE), .ADDR_HI(ADDR_HI),
    .SET_LO(SET_LO), .CLR_LO(CLR_LO), .DATA_CODE(DATA_CODE)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .hold_i     (busy),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_data),
    .wel_i      (wel),
    .hv_i       (hv_on_wp),
    .frame_ok_o (frame_ok),
    .op_o       (frame_op)
  );

  vtrip_launch_ctrl u_launch (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .frame_ok_i (frame_ok),
    .op_i       (frame_op),
    .hv_i       (hv_on_wp),
    .busy_o     (busy),
    .set_o      (set_req),
    .clr_o      (clr_req)
  );
endmodule

// File: rtl/vtrip_prog_seq_chk.sv
module vtrip_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_stop,
  input logic hv_on_wp,
  input logic set_req,
  input logic clr_req,
  input logic busy
);
  assert_req_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_req, clr_req}));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (set_req || clr_req));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hv_on_wp |=> busy && $stable(set_req) && $stable(clr_req));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !hv_on_wp |=> !busy && !set_req && !clr_req);

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop) && $past(hv_on_wp));
endmodule

bind vtrip_prog_seq vtrip_prog_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_stop (bus_stop),
  .hv_on_wp (hv_on_wp),
  .set_req  (set_req),
  .clr_req  (clr_req),
  .busy     (busy)
);

// File: tb/test_vtrip_prog_seq.sv
module test_vtrip_prog_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic wel = 1'b0, hv_on_wp = 1'b0;
  logic set_req, clr_req, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // frame description used by the reference model
  logic [7:0] fb [0:5];
  logic       fhv [0:5];
  int         fn;
  logic       fwel;
  logic       fhv_stop;

  always #2 clk = ~clk;

  vtrip_prog_seq i_vtrip_prog_seq (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .wel(wel), .hv_on_wp(hv_on_wp),
    .set_req(set_req), .clr_req(clr_req), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected {busy,set,clr} after the STOP
  function automatic logic [2:0] exp_code();
    if (!fwel || fn != 4 || !fhv_stop) return 3'b000;
    for (int i = 0; i < 4; i++) if (!fhv[i]) return 3'b000;
    if (fb[0] != 8'hA0 || fb[1] != 8'h00 || fb[3] != 8'h00) return 3'b000;
    if (fb[2] == 8'h01) return 3'b110;
    if (fb[2] == 8'h03) return 3'b101;
    return 3'b000;
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {busy, set_req, clr_req};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_start();
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b, input logic h);
    byte_data = b; byte_vld = 1'b1; hv_on_wp = h;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_stop(input logic h);
    bus_stop = 1'b1; hv_on_wp = h;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic set_frame(input logic [7:0] lo);
    fb[0] = 8'hA0; fb[1] = 8'h00; fb[2] = lo; fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = 8'h00;
    for (int i = 0; i < 6; i++) fhv[i] = 1'b1;
    fn = 4; fwel = 1'b1; fhv_stop = 1'b1;
  endtask

  task automatic send_frame(input logic wel_late);
    wel = fwel;
    hv_on_wp = 1'b1;
    do_start();
    wel = wel_late;
    for (int i = 0; i < fn; i++) do_byte(fb[i], fhv[i]);
    do_stop(fhv_stop);
  endtask

  task automatic release_hv(input string tag);
    hv_on_wp = 1'b0;
    @(negedge clk);
    chk(tag, 3'b000);
    hv_on_wp = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 in reset", 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 3'b000);

    // R2 set frame, hold, ignore while busy, release
    set_frame(8'h01); send_frame(1'b1);
    chk("R2 set frame", 3'b110);
    repeat (3) @(negedge clk);
    chk("R9 hold", 3'b110);
    set_frame(8'h03); send_frame(1'b1);
    chk("R11 ignored while busy", 3'b110);
    release_hv("R10 release");

    // R11 no START after release
    do_byte(8'hA0, 1'b1); do_byte(8'h00, 1'b1); do_byte(8'h01, 1'b1); do_byte(8'h00, 1'b1);
    do_stop(1'b1);
    chk("R11 no start", 3'b000);

    // R3 reset frame
    set_frame(8'h03); send_frame(1'b1);
    chk("R3 clr frame", 3'b101);
    release_hv("R10 release clr");

    // R4 wel low at START, high later
    set_frame(8'h01); fwel = 1'b0; send_frame(1'b1);
    chk("R4 wel late", 3'b000);

    // R5 hv low on one byte, and at STOP
    set_frame(8'h01); fhv[2] = 1'b0; send_frame(1'b1);
    chk("R5 hv byte", 3'b000);
    set_frame(8'h03); fhv_stop = 1'b0; send_frame(1'b1);
    chk("R5 hv stop", 3'b000);

    // R6 mismatches
    set_frame(8'h01); fb[0] = 8'hA2; send_frame(1'b1);
    chk("R6 device byte", 3'b000);
    set_frame(8'h01); fb[3] = 8'h01; send_frame(1'b1);
    chk("R6 data byte", 3'b000);
    set_frame(8'h02); send_frame(1'b1);
    chk("R6 low address", 3'b000);

    // R7 short and long frames
    set_frame(8'h01); fn = 3; send_frame(1'b1);
    chk("R7 short", 3'b000);
    set_frame(8'h01); fn = 5; send_frame(1'b1);
    chk("R7 long", 3'b000);

    // R8 restart mid-frame
    wel = 1'b1; hv_on_wp = 1'b1;
    do_start(); do_byte(8'hA0, 1'b1); do_byte(8'h00, 1'b1);
    do_start(); do_byte(8'hA0, 1'b1); do_byte(8'h00, 1'b1);
    do_byte(8'h01, 1'b1); do_byte(8'h00, 1'b1);
    do_stop(1'b1);
    chk("R8 restart", 3'b110);
    release_hv("R10 release restart");

    // random frames against the reference model
    for (int n = 0; n < 400; n++) begin
      logic [2:0] e;
      set_frame(($urandom % 2) ? 8'h01 : 8'h03);
      fn = 3 + int'($urandom % 3);
      if ($urandom % 3 == 0) fb[$urandom % 6] = 8'($urandom);
      fwel = ($urandom % 4) != 0;
      for (int i = 0; i < 6; i++) fhv[i] = ($urandom % 10) != 0;
      fhv_stop = ($urandom % 10) != 0;
      e = exp_code();
      send_frame(1'($urandom));
      chk("R2/R3 random frame", e);
      if (e != 3'b000) begin
        hv_on_wp = 1'b1;
        repeat (1 + int'($urandom % 4)) @(negedge clk);
        chk("R9 random hold", e);
        release_hv("R10 random release");
      end else begin
        hv_on_wp = 1'b1;
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule